// File: doc/BRIEF.md
# Processor Exception Control Unit

This block keeps the privileged exception state of a small 32-bit processor core. Each cycle the pipeline presents its exception requests: an external interrupt line, an address fault flag together with the faulting virtual address, a translation miss flag, an illegal opcode flag, an overflow flag and a system call flag. With them comes the PC of the instruction that raised the request. The block accepts at most one request per cycle. It records where to restart, why the exception happened and, for address faults, which address faulted. It then switches the core into kernel mode with interrupts masked and asks the fetch stage to redirect to a handler entry point.

A return strobe from the handler undoes the switch in one step. It drops back to user mode, unmasks interrupts and redirects fetch to the saved restart PC. Software reads the three privileged registers through a two-bit select port with combinational read data. Fetch redirection arrives as a one-cycle valid pulse with a target PC, one clock after the request.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the block is in kernel mode with interrupts masked, no redirect is pending, and the restart PC, cause and bad address registers all read zero.
- R2: Every accepted exception copies `instr_pc` into the restart PC register at the clock edge where it is accepted.
- R3: In the cycle after an accepted exception, `kernel_mode` is 1 and `int_en` is 0. Both change at the same edge.
- R4: An accepted exception writes its reason code into the cause register. The codes are interrupt 0, translation miss 2, address fault 4, system call 8, illegal opcode 10 and overflow 12.
- R5: The bad address register loads `fault_vaddr` only when the serviced exception is an address fault or a translation miss. Any other exception leaves it unchanged.
- R6: The redirect target is 0x8000_0000 for a serviced translation miss and 0x8000_0180 for every other exception, system calls included.
- R7: A return strobe with no accepted exception sets user mode (`kernel_mode`=0) and `int_en`=1, and redirects to the restart PC register value.
- R8: When several requests arrive in one cycle, only the highest-priority one is serviced. The order is address fault, translation miss, illegal opcode, overflow, system call, interrupt.
- R9: An interrupt request has no effect while in kernel mode or while interrupts are masked. Synchronous requests are accepted in any mode.
- R10: When an accepted exception and a return strobe occur in the same cycle, the exception is serviced and the return is dropped.
- R11: `rd_data` shows the restart PC for `rd_sel`=0, the zero-extended cause for `rd_sel`=1, the bad address for `rd_sel`=2 and zero for `rd_sel`=3.
- R12: `redir_valid` is high for exactly one cycle after each accepted exception or return, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | External interrupt request |
| addr_err | input | 1 | Address fault on the current instruction |
| tlb_miss | input | 1 | Translation miss on the current instruction |
| illegal_op | input | 1 | Illegal opcode on the current instruction |
| syscall_req | input | 1 | System call instruction |
| ovf_req | input | 1 | Arithmetic overflow |
| fault_vaddr | input | 32 | Faulting virtual address |
| instr_pc | input | 32 | PC of the instruction owning the request |
| eret | input | 1 | Return-from-exception strobe |
| rd_sel | input | 2 | Privileged register select |
| rd_data | output | 32 | Selected register value |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | 32 | Fetch redirect target |
| kernel_mode | output | 1 | 1 = kernel mode, 0 = user mode |
| int_en | output | 1 | Interrupt enable |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 5-bit cause field, separate refill and common entry points, and translation misses loading the bad address. With these values both vector targets and the bad address rule for both fault kinds can be checked. The scoreboard orders every redirect pulse and reads back all registers after each step. That covers the full priority chain, interrupt masking in kernel mode and the case where an exception and a return collide.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NSRC   = 6;
   localparam int SRC_W  = $clog2(NSRC);
   localparam int CODE_W = 4;

   // Index doubles as service priority: 0 wins.
   typedef enum logic [SRC_W-1:0] {
      SRC_ADDR = 3'd0,
      SRC_TLB  = 3'd1,
      SRC_ILL  = 3'd2,
      SRC_OVF  = 3'd3,
      SRC_SYS  = 3'd4,
      SRC_IRQ  = 3'd5
   } exc_src_e;

   typedef enum logic [1:0] {
      RSEL_EPC   = 2'd0,
      RSEL_CAUSE = 2'd1,
      RSEL_BAD   = 2'd2,
      RSEL_NONE  = 2'd3
   } rsel_e;

   function automatic logic [CODE_W-1:0] code_of(input logic [SRC_W-1:0] s);
      case (s)
         SRC_ADDR: code_of = CODE_W'(4);
         SRC_TLB:  code_of = CODE_W'(2);
         SRC_ILL:  code_of = CODE_W'(10);
         SRC_OVF:  code_of = CODE_W'(12);
         SRC_SYS:  code_of = CODE_W'(8);
         default:  code_of = CODE_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
   parameter int N = 6
) (
   input  logic [N-1:0]         req,
   output logic                 hit,
   output logic [$clog2(N)-1:0] sel
);
   localparam int IW = $clog2(N);

   always_comb begin
      hit = |req;
      sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) sel = IW'(i);
      end
   end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
   parameter int          XLEN         = 32,
   parameter logic [31:0] VEC_REFILL   = 32'h8000_0000,
   parameter logic [31:0] VEC_GENERAL  = 32'h8000_0180,
   parameter bit          SPLIT_REFILL = 1'b1
) (
   input  logic            is_refill,
   output logic [XLEN-1:0] target
);
   localparam logic [XLEN-1:0] REF_X = XLEN'(VEC_REFILL);
   localparam logic [XLEN-1:0] GEN_X = XLEN'(VEC_GENERAL);

   generate
      if (SPLIT_REFILL) begin : g_split
         assign target = is_refill ? REF_X : GEN_X;
      end else begin : g_single
         logic unused_refill;
         assign unused_refill = is_refill;
         assign target        = GEN_X;
      end
   endgenerate
endmodule

// File: rtl/exc_csr.sv
module exc_csr
   import exc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int CAUSE_W    = 5,
   parameter bit BAD_ON_TLB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [SRC_W-1:0]   take_src,
   input  logic [XLEN-1:0]    take_pc,
   input  logic [XLEN-1:0]    fault_va,
   input  logic [XLEN-1:0]    vec_pc,
   input  logic               eret,
   input  logic [1:0]         rd_sel,
   output logic [XLEN-1:0]    rd_data,
   output logic               redir_valid,
   output logic [XLEN-1:0]    redir_pc,
   output logic               kernel_mode,
   output logic               int_en,
   output logic [XLEN-1:0]    epc_o
);
   logic [XLEN-1:0]    epc_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [XLEN-1:0]    bad_q;
   logic               bad_we;
   logic               is_addr;
   logic               is_tlb;
   logic               ret_go;

   assign is_addr = (take_src == SRC_ADDR);
   assign is_tlb  = (take_src == SRC_TLB);
   assign ret_go  = eret && !take;

   generate
      if (BAD_ON_TLB) begin : g_bad_both
         assign bad_we = take && (is_addr || is_tlb);
      end else begin : g_bad_addr
         logic unused_tlb;
         assign unused_tlb = is_tlb;
         assign bad_we     = take && is_addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q       <= '0;
         cause_q     <= '0;
         bad_q       <= '0;
         kernel_mode <= 1'b1;
         int_en      <= 1'b0;
         redir_valid <= 1'b0;
         redir_pc    <= '0;
      end else begin
         redir_valid <= take || ret_go;
         if (take) begin
            epc_q       <= take_pc;
            cause_q     <= CAUSE_W'(code_of(take_src));
            kernel_mode <= 1'b1;
            int_en      <= 1'b0;
            redir_pc    <= vec_pc;
         end else if (ret_go) begin
            kernel_mode <= 1'b0;
            int_en      <= 1'b1;
            redir_pc    <= epc_q;
         end
         if (bad_we) bad_q <= fault_va;
      end
   end

   always_comb begin
      case (rsel_e'(rd_sel))
         RSEL_EPC:   rd_data = epc_q;
         RSEL_CAUSE: rd_data = XLEN'(cause_q);
         RSEL_BAD:   rd_data = bad_q;
         default:    rd_data = '0;
      endcase
   end

   assign epc_o = epc_q;
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          CAUSE_W      = 5,
   parameter logic [31:0] VEC_REFILL   = 32'h8000_0000,
   parameter logic [31:0] VEC_GENERAL  = 32'h8000_0180,
   parameter bit          SPLIT_REFILL = 1'b1,
   parameter bit          BAD_ON_TLB   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic            addr_err,
   input  logic            tlb_miss,
   input  logic            illegal_op,
   input  logic            syscall_req,
   input  logic            ovf_req,
   input  logic [XLEN-1:0] fault_vaddr,
   input  logic [XLEN-1:0] instr_pc,
   input  logic            eret,
   input  logic [1:0]      rd_sel,
   output logic [XLEN-1:0] rd_data,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_pc,
   output logic            kernel_mode,
   output logic            int_en
);
   if (XLEN < 8) begin : g_chk_xlen
      $error("exc_ctrl_unit: XLEN must be at least 8");
   end
   if (CAUSE_W < CODE_W || CAUSE_W > XLEN) begin : g_chk_cause
      $error("exc_ctrl_unit: CAUSE_W must hold every code and fit in XLEN");
   end
   if (VEC_REFILL[1:0] != 2'b00 || VEC_GENERAL[1:0] != 2'b00) begin : g_chk_vec
      $error("exc_ctrl_unit: entry points must be word aligned");
   end

   logic [NSRC-1:0]  req;
   logic             irq_ok;
   logic             take;
   logic [SRC_W-1:0] take_src;
   logic [XLEN-1:0]  vec_pc;
   logic [XLEN-1:0]  epc_w;

   assign irq_ok = irq_req && int_en && !kernel_mode;

   always_comb begin
      req           = '0;
      req[SRC_ADDR] = addr_err;
      req[SRC_TLB]  = tlb_miss;
      req[SRC_ILL]  = illegal_op;
      req[SRC_OVF]  = ovf_req;
      req[SRC_SYS]  = syscall_req;
      req[SRC_IRQ]  = irq_ok;
   end

   exc_prio #(.N(NSRC)) u_prio (
      .req (req),
      .hit (take),
      .sel (take_src)
   );

   exc_vector #(
      .XLEN         (XLEN),
      .VEC_REFILL   (VEC_REFILL),
      .VEC_GENERAL  (VEC_GENERAL),
      .SPLIT_REFILL (SPLIT_REFILL)
   ) u_vec (
      .is_refill (take_src == SRC_TLB),
      .target    (vec_pc)
   );

   exc_csr #(
      .XLEN       (XLEN),
      .CAUSE_W    (CAUSE_W),
      .BAD_ON_TLB (BAD_ON_TLB)
   ) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take),
      .take_src    (take_src),
      .take_pc     (instr_pc),
      .fault_va    (fault_vaddr),
      .vec_pc      (vec_pc),
      .eret        (eret),
      .rd_sel      (rd_sel),
      .rd_data     (rd_data),
      .redir_valid (redir_valid),
      .redir_pc    (redir_pc),
      .kernel_mode (kernel_mode),
      .int_en      (int_en),
      .epc_o       (epc_w)
   );
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
module exc_ctrl_unit_chk #(
   parameter int          XLEN        = 32,
   parameter logic [31:0] VEC_REFILL  = 32'h8000_0000,
   parameter logic [31:0] VEC_GENERAL = 32'h8000_0180
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            addr_err,
   input logic            tlb_miss,
   input logic            illegal_op,
   input logic            syscall_req,
   input logic            ovf_req,
   input logic [XLEN-1:0] instr_pc,
   input logic            eret,
   input logic            redir_valid,
   input logic [XLEN-1:0] redir_pc,
   input logic            kernel_mode,
   input logic            int_en,
   input logic [XLEN-1:0] epc_q
);
   logic sync_req;
   assign sync_req = addr_err || tlb_miss || illegal_op || syscall_req || ovf_req;

   // R3
   a_r3_enter_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> (kernel_mode && !int_en));

   // R2
   a_r2_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> (epc_q == $past(instr_pc)));

   // R6
   a_r6_refill_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_miss && !addr_err) |=> (redir_valid && redir_pc == XLEN'(VEC_REFILL)));

   a_r6_common_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_req && !tlb_miss) |=> (redir_valid && redir_pc == XLEN'(VEC_GENERAL)));

   // R9
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_req && !eret && (kernel_mode || !int_en)) |=> (!redir_valid && $stable(epc_q)));

   // R7
   a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && !sync_req && !(irq_req && int_en && !kernel_mode))
         |=> (!kernel_mode && int_en && redir_valid && redir_pc == $past(epc_q)));
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(
   .XLEN        (XLEN),
   .VEC_REFILL  (VEC_REFILL),
   .VEC_GENERAL (VEC_GENERAL)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_req     (irq_req),
   .addr_err    (addr_err),
   .tlb_miss    (tlb_miss),
   .illegal_op  (illegal_op),
   .syscall_req (syscall_req),
   .ovf_req     (ovf_req),
   .instr_pc    (instr_pc),
   .eret        (eret),
   .redir_valid (redir_valid),
   .redir_pc    (redir_pc),
   .kernel_mode (kernel_mode),
   .int_en      (int_en),
   .epc_q       (epc_w)
);

// File: tb/exc_ctrl_unit_test.sv
`timescale 1ns/1ps
module exc_ctrl_unit_test;
   localparam logic [31:0] VREF = 32'h8000_0000;
   localparam logic [31:0] VGEN = 32'h8000_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 0, addr_err = 0, tlb_miss = 0, illegal_op = 0;
   logic        syscall_req = 0, ovf_req = 0, eret = 0;
   logic [31:0] fault_vaddr = '0, instr_pc = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data, redir_pc;
   logic        redir_valid, kernel_mode, int_en;

   always #2 clk = ~clk;

   exc_ctrl_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .addr_err(addr_err),
      .tlb_miss(tlb_miss), .illegal_op(illegal_op), .syscall_req(syscall_req),
      .ovf_req(ovf_req), .fault_vaddr(fault_vaddr), .instr_pc(instr_pc),
      .eret(eret), .rd_sel(rd_sel), .rd_data(rd_data), .redir_valid(redir_valid),
      .redir_pc(redir_pc), .kernel_mode(kernel_mode), .int_en(int_en)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] exp_q[$];

   // Requirement model
   bit          m_k = 1, m_ie = 0;
   logic [31:0] m_epc = '0, m_cause = '0, m_bad = '0;

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_regs(input string req);
      rd_sel = 2'd0; #0.3; check32({req, " R11 epc"}, rd_data, m_epc);
      rd_sel = 2'd1; #0.3; check32({req, " R11 cause"}, rd_data, m_cause);
      rd_sel = 2'd2; #0.3; check32({req, " R11 bad"}, rd_data, m_bad);
      rd_sel = 2'd3; #0.3; check32({req, " R11 none"}, rd_data, 32'h0);
   endtask

   task automatic step(input bit a_irq, input bit a_addr, input bit a_tlb, input bit a_ill,
                       input bit a_sys, input bit a_ovf, input bit a_ret,
                       input logic [31:0] pc, input logic [31:0] va, input string req);
      bit sync, irq_ok;
      @(negedge clk); #1;
      irq_req = a_irq; addr_err = a_addr; tlb_miss = a_tlb; illegal_op = a_ill;
      syscall_req = a_sys; ovf_req = a_ovf; eret = a_ret; instr_pc = pc; fault_vaddr = va;
      sync   = a_addr | a_tlb | a_ill | a_sys | a_ovf;
      irq_ok = a_irq && m_ie && !m_k;
      if (sync || irq_ok) begin
         m_epc = pc;
         if (a_addr)     m_cause = 32'd4;
         else if (a_tlb) m_cause = 32'd2;
         else if (a_ill) m_cause = 32'd10;
         else if (a_ovf) m_cause = 32'd12;
         else if (a_sys) m_cause = 32'd8;
         else            m_cause = 32'd0;
         if (a_addr || a_tlb) m_bad = va;
         m_k = 1; m_ie = 0;
         exp_q.push_back((a_tlb && !a_addr) ? VREF : VGEN);
      end else if (a_ret) begin
         m_k = 0; m_ie = 1;
         exp_q.push_back(m_epc);
      end
      @(posedge clk); #1;
      irq_req = 0; addr_err = 0; tlb_miss = 0; illegal_op = 0;
      syscall_req = 0; ovf_req = 0; eret = 0;
      check32({req, " R3 R7 kernel_mode"}, {31'b0, kernel_mode}, {31'b0, m_k});
      check32({req, " R3 R7 int_en"}, {31'b0, int_en}, {31'b0, m_ie});
      read_regs(req);
   endtask

   // Scoreboard monitor: one expected target per redirect pulse (R12, R6, R7)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (redir_valid) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R12 unexpected redirect actual=%h expected=none", redir_pc);
            end else begin
               check32("R6 R7 R12 redirect target", redir_pc, exp_q.pop_front());
            end
         end else if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 missing redirect actual=none expected=%h", exp_q[0]);
            void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check32("R1 kernel_mode", {31'b0, kernel_mode}, 32'd1);
      check32("R1 int_en", {31'b0, int_en}, 32'd0);
      check32("R1 redir_valid", {31'b0, redir_valid}, 32'd0);
      read_regs("R1");
      rst_n = 1'b1;

      step(1,0,0,0,0,0,0, 32'h0040_0004, 32'h0, "R9 irq in kernel");
      step(0,0,0,0,1,0,0, 32'h0040_0010, 32'h0, "R9 R4 syscall in kernel");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(1,0,0,0,0,0,0, 32'h0040_0020, 32'h5555_0000, "R5 R4 irq accepted");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(0,0,1,0,0,0,0, 32'h0040_0030, 32'h1234_5678, "R6 R5 tlb miss");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(1,1,1,0,0,0,0, 32'h0040_0040, 32'hDEAD_0001, "R8 addr over tlb");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(1,0,0,1,1,1,0, 32'h0040_0050, 32'h7777_0000, "R8 illegal first");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(1,0,0,0,1,1,0, 32'h0040_0060, 32'h0, "R8 overflow over syscall");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(1,0,0,0,1,0,0, 32'h0040_0070, 32'h0, "R8 syscall over irq");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(0,0,0,0,0,1,1, 32'h0040_0080, 32'h0, "R10 exception beats return");
      step(1,0,0,0,0,0,0, 32'h0040_0084, 32'h0, "R9 irq masked after exception");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return");
      step(0,0,0,0,0,0,0, 32'h0, 32'h0, "R12 idle");
      step(0,0,0,0,0,0,1, 32'h0, 32'h0, "R7 return from user");

      repeat (3) @(negedge clk);
      #1;
      check32("R12 queue drained", exp_q.size(), 32'd0);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule